// File: doc/BRIEF.md
# Dual-Rail / Quaternary One-Hot Code Converter

This block bridges two delay-insensitive codes. On its combining side, each digit position takes a pair of dual-rail bits and produces one four-wire one-hot quaternary digit. On its separating side, each digit position takes a four-wire one-hot digit and produces the two matching dual-rail bits. Both sides follow a return-to-zero discipline, in which every valid code word is followed by an all-zero spacer word.

The combining side holds its result until the inputs return to spacer. It raises no quaternary wire until both of its dual-rail inputs carry data. After that, it keeps the digit until both inputs are back at spacer. Each side reports illegal input codes. Each side also has one flag for "every output group carries data" and one for "every output group is at spacer", so a surrounding handshake can detect when the data phase or the spacer phase is complete. An optional output register stage lets the block run inside a clocked environment.

The data interface is the code itself. A spacer separates one word from the next, so there is no valid/ready pair and no back-pressure. The block samples its inputs on every clock edge. A sender must not start the next word until it sees the null flag of the side it feeds.

Top module: `drq_converter`

## Requirements
- R1: A dual-rail pair uses two wires. Bit 1 is the true rail and bit 0 is the false rail: 10 is logic 1, 01 is logic 0, 00 is spacer and 11 is illegal. In digit d of `mix_dr_i`, bits [4d+3:4d+2] form the high pair and bits [4d+1:4d] form the low pair. `spl_dr_o` uses the same layout.
- R2: A quaternary digit is the nibble [4d+3:4d]. Value v is shown by setting bit v alone, and 0000 is spacer. When both pairs of a digit carry data, the combining side emits value 2*high + low.
- R3: A combining digit keeps 0000 while it is at spacer and either of its pairs is still spacer or illegal.
- R4: Once a combining digit shows data, it keeps that data while any one of its pairs is not spacer. It returns to 0000 only when both pairs are 00.
- R5: A separating digit that receives value v drives the high pair to bit 1 of v and the low pair to bit 0 of v, using the dual-rail code of R1.
- R6: A separating digit drives 00 00 when its nibble is 0000, and also when its nibble has more than one wire set.
- R7: `mix_err_o` is high when any input pair is 11. `spl_err_o` is high when any input nibble has more than one wire set.
- R8: `mix_done_o` is high only when every combining output digit has exactly one wire set. `spl_done_o` is high only when every separating output pair is 01 or 10.
- R9: `mix_null_o` is high only when every combining output wire is 0. `spl_null_o` is high only when every separating output wire is 0.
- R10: With REG_OUT=1, every output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, the data outputs are all zero, both null flags are 1, and the done and error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold state and the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mix_dr_i | input | 4*NUM_DIGITS | Dual-rail pairs into the combining side |
| mix_q_o | output | 4*NUM_DIGITS | One-hot quaternary digits out of the combining side |
| mix_err_o | output | 1 | Illegal dual-rail pair seen on the input |
| mix_done_o | output | 1 | All combining output digits carry data |
| mix_null_o | output | 1 | All combining output digits are spacer |
| spl_q_i | input | 4*NUM_DIGITS | One-hot quaternary digits into the separating side |
| spl_dr_o | output | 4*NUM_DIGITS | Dual-rail pairs out of the separating side |
| spl_err_o | output | 1 | Nibble with more than one wire seen on the input |
| spl_done_o | output | 1 | All separating output pairs carry data |
| spl_null_o | output | 1 | All separating output pairs are spacer |

## Verification
The hold-state assertions assume a return-to-zero sender. Once a combining digit holds a value, its inputs never jump straight to a different complete data word; they pass through a full spacer first. The stimulus follows this rule. Every data word is followed by a spacer. Partial spacers and illegal 11 pairs are placed only where they cannot complete a second, different word. Separating-side stimulus may change between any two nibbles, including illegal ones, because that side keeps no state.

// File: rtl/drq_pkg.sv
package drq_pkg;

  typedef logic [1:0] rail_pair_t;
  typedef logic [3:0] quad_t;

  localparam rail_pair_t PAIR_SPACER = 2'b00;
  localparam rail_pair_t PAIR_ZERO   = 2'b01;
  localparam rail_pair_t PAIR_ONE    = 2'b10;
  localparam quad_t      QUAD_SPACER = 4'b0000;

  function automatic logic pair_is_data(input rail_pair_t p);
    return (p == PAIR_ZERO) || (p == PAIR_ONE);
  endfunction

  function automatic logic pair_is_bad(input rail_pair_t p);
    return p == 2'b11;
  endfunction

  function automatic quad_t pairs_to_quad(input rail_pair_t hi, input rail_pair_t lo);
    return quad_t'(4'b0001 << {hi[1], lo[1]});
  endfunction

  function automatic logic quad_multi(input quad_t q);
    return (q & (q - 4'd1)) != 4'd0;
  endfunction

  function automatic rail_pair_t bit_to_pair(input logic b);
    return b ? PAIR_ONE : PAIR_ZERO;
  endfunction

endpackage

// File: rtl/drq_mix_digit.sv
module drq_mix_digit
  import drq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rail_pair_t hi_i,
  input  rail_pair_t lo_i,
  output quad_t      q_o,
  output logic       err_o
);

  quad_t hold_q;
  logic  both_data;
  logic  both_spacer;

  assign both_data   = pair_is_data(hi_i) && pair_is_data(lo_i);
  assign both_spacer = (hi_i == PAIR_SPACER) && (lo_i == PAIR_SPACER);
  assign err_o       = pair_is_bad(hi_i) || pair_is_bad(lo_i);

  always_comb begin
    if (both_data)        q_o = pairs_to_quad(hi_i, lo_i);
    else if (both_spacer) q_o = QUAD_SPACER;
    else                  q_o = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= QUAD_SPACER;
    else        hold_q <= q_o;
  end

  AST_MIX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_o)); // R2
  AST_MIX_WAIT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q == QUAD_SPACER && !both_data) |-> q_o == QUAD_SPACER); // R3
  AST_MIX_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != QUAD_SPACER && !both_spacer) |-> q_o == hold_q); // R4
  AST_MIX_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o != QUAD_SPACER) |=> hold_q == $past(q_o)); // R4

endmodule

// File: rtl/drq_split_digit.sv
module drq_split_digit
  import drq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  quad_t      q_i,
  output rail_pair_t hi_o,
  output rail_pair_t lo_o,
  output logic       err_o
);

  always_comb begin
    unique case (q_i)
      4'b0001: begin hi_o = PAIR_ZERO; lo_o = PAIR_ZERO; end
      4'b0010: begin hi_o = PAIR_ZERO; lo_o = PAIR_ONE;  end
      4'b0100: begin hi_o = PAIR_ONE;  lo_o = PAIR_ZERO; end
      4'b1000: begin hi_o = PAIR_ONE;  lo_o = PAIR_ONE;  end
      default: begin hi_o = PAIR_SPACER; lo_o = PAIR_SPACER; end
    endcase
  end

  assign err_o = quad_multi(q_i);

  AST_SPL_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
    (q_i == QUAD_SPACER) |-> (hi_o == PAIR_SPACER && lo_o == PAIR_SPACER)); // R6
  AST_SPL_NO_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_is_bad(hi_o) && !pair_is_bad(lo_o)); // R5
  AST_SPL_ERR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (hi_o == PAIR_SPACER && lo_o == PAIR_SPACER)); // R6

endmodule

// File: rtl/drq_out_stage.sv
module drq_out_stage #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end
      AST_STAGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) or 1'b1 |=> q_o == $past(d_i)); // R10
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/drq_converter.sv
module drq_converter
  import drq_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4*NUM_DIGITS-1:0] mix_dr_i,
  output logic [4*NUM_DIGITS-1:0] mix_q_o,
  output logic                    mix_err_o,
  output logic                    mix_done_o,
  output logic                    mix_null_o,
  input  logic [4*NUM_DIGITS-1:0] spl_q_i,
  output logic [4*NUM_DIGITS-1:0] spl_dr_o,
  output logic                    spl_err_o,
  output logic                    spl_done_o,
  output logic                    spl_null_o
);

  localparam int BUS_W   = 4 * NUM_DIGITS;
  localparam int STAGE_W = 2 * BUS_W + 2;

  logic [BUS_W-1:0]      mix_q_raw;
  logic [BUS_W-1:0]      spl_dr_raw;
  logic [NUM_DIGITS-1:0] mix_err_d;
  logic [NUM_DIGITS-1:0] spl_err_d;
  logic [STAGE_W-1:0]    stage_d;
  logic [STAGE_W-1:0]    stage_q;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    drq_mix_digit u_mix (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_i  (mix_dr_i[4*d+2 +: 2]),
      .lo_i  (mix_dr_i[4*d   +: 2]),
      .q_o   (mix_q_raw[4*d +: 4]),
      .err_o (mix_err_d[d])
    );
    drq_split_digit u_spl (
      .clk   (clk),
      .rst_n (rst_n),
      .q_i   (spl_q_i[4*d +: 4]),
      .hi_o  (spl_dr_raw[4*d+2 +: 2]),
      .lo_o  (spl_dr_raw[4*d   +: 2]),
      .err_o (spl_err_d[d])
    );
  end

  assign stage_d = {mix_q_raw, spl_dr_raw, |mix_err_d, |spl_err_d};

  drq_out_stage #(.WIDTH(STAGE_W), .REG_OUT(REG_OUT)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (stage_d),
    .q_o   (stage_q)
  );

  assign {mix_q_o, spl_dr_o, mix_err_o, spl_err_o} = stage_q;

  always_comb begin
    mix_done_o = 1'b1;
    spl_done_o = 1'b1;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (mix_q_o[4*d +: 4] == QUAD_SPACER)     mix_done_o = 1'b0;
      if (!pair_is_data(spl_dr_o[4*d+2 +: 2]) ||
          !pair_is_data(spl_dr_o[4*d +: 2]))    spl_done_o = 1'b0;
    end
  end

  assign mix_null_o = (mix_q_o == '0);
  assign spl_null_o = (spl_dr_o == '0);

  AST_MIX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mix_done_o && mix_null_o)); // R8
  AST_SPL_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(spl_done_o && spl_null_o)); // R9
  AST_MIX_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mix_done_o |-> ($countones(mix_q_o) == NUM_DIGITS)); // R8

endmodule

// File: tb/drq_converter_bench.sv
module drq_converter_bench;
  import drq_pkg::*;

  localparam int N = 2;
  localparam int W = 4 * N;

  typedef struct {
    logic [W-1:0] mq;
    logic [W-1:0] sd;
    logic         merr, serr, mdone, mnull, sdone, snull;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mix_in = '0;
  logic [W-1:0] spl_in = '0;
  logic [W-1:0] mix_q_o, spl_dr_o;
  logic         mix_err_o, mix_done_o, mix_null_o;
  logic         spl_err_o, spl_done_o, spl_null_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done_run = 1'b0;
  exp_t  sb[$];
  logic [3:0] mstate [N];

  always #5 clk = ~clk;

  drq_converter #(.NUM_DIGITS(N), .REG_OUT(1'b1)) u_drq_converter (
    .clk(clk), .rst_n(rst_n),
    .mix_dr_i(mix_in), .mix_q_o(mix_q_o), .mix_err_o(mix_err_o),
    .mix_done_o(mix_done_o), .mix_null_o(mix_null_o),
    .spl_q_i(spl_in), .spl_dr_o(spl_dr_o), .spl_err_o(spl_err_o),
    .spl_done_o(spl_done_o), .spl_null_o(spl_null_o)
  );

  function automatic logic [1:0] b2p(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  task automatic drive(input logic [W-1:0] m, input logic [W-1:0] s, input string tag);
    exp_t e;
    @(negedge clk);
    mix_in = m;
    spl_in = s;
    e.mq = '0; e.sd = '0; e.merr = 1'b0; e.serr = 1'b0;
    e.mdone = 1'b1; e.sdone = 1'b1;
    for (int d = 0; d < N; d++) begin
      logic [1:0] hi, lo;
      logic [3:0] nib, o;
      hi = m[4*d+2 +: 2];
      lo = m[4*d +: 2];
      if (hi == 2'b11 || lo == 2'b11) e.merr = 1'b1;
      if ((hi == 2'b01 || hi == 2'b10) && (lo == 2'b01 || lo == 2'b10))
        o = 4'b0001 << (2 * int'(hi[1]) + int'(lo[1]));
      else if (hi == 2'b00 && lo == 2'b00)
        o = 4'b0000;
      else
        o = mstate[d];
      mstate[d] = o;
      e.mq[4*d +: 4] = o;
      if (o == 4'b0000) e.mdone = 1'b0;
      nib = s[4*d +: 4];
      if ($countones(nib) > 1) e.serr = 1'b1;
      if ($countones(nib) == 1) begin
        for (int k = 0; k < 4; k++)
          if (nib[k]) e.sd[4*d +: 4] = {b2p(k[1]), b2p(k[0])};
      end else begin
        e.sdone = 1'b0;
      end
    end
    e.mnull = (e.mq == '0);
    e.snull = (e.sd == '0);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string what, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(mix_q_o, e.mq, "mix_q", e.tag);
        chk(spl_dr_o, e.sd, "spl_dr", e.tag);
        chk(W'({mix_err_o, spl_err_o}), W'({e.merr, e.serr}), "err", e.tag);
        chk(W'({mix_done_o, mix_null_o, spl_done_o, spl_null_o}),
            W'({e.mdone, e.mnull, e.sdone, e.snull}), "flags", e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int d = 0; d < N; d++) mstate[d] = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(mix_q_o, '0, "reset mix_q", "R10");
    chk(spl_dr_o, '0, "reset spl_dr", "R10");
    chk(W'({mix_err_o, spl_err_o, mix_done_o, mix_null_o, spl_done_o, spl_null_o}),
        W'(6'b000101), "reset flags", "R10");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: every value on both digits, spacer between words
    for (int v = 0; v < 4; v++) begin
      logic [3:0] dig;
      dig = {b2p(v[1]), b2p(v[0])};
      drive({dig, dig}, '0, "R2");
      drive('0, '0, "R1");
    end
    // R3: partial inputs never raise a wire
    drive({4'b0000, 4'b1000}, '0, "R3");
    drive({4'b0010, 4'b0000}, '0, "R3");
    drive({4'b1100, 4'b0001}, '0, "R3");
    drive('0, '0, "R3");
    // R4: data held through a partial spacer, cleared on full spacer
    drive({4'b1001, 4'b0110}, '0, "R4");
    drive({4'b1000, 4'b0010}, '0, "R4");
    drive({4'b0001, 4'b0100}, '0, "R4");
    drive({4'b0000, 4'b0100}, '0, "R4");
    drive('0, '0, "R4");
    // R7: illegal 11 pair with a held digit
    drive({4'b0101, 4'b1010}, '0, "R7");
    drive({4'b0111, 4'b1100}, '0, "R7");
    drive('0, '0, "R7");
    // R5: every one-hot value on the separating side
    drive('0, {4'b0001, 4'b1000}, "R5");
    drive('0, {4'b0010, 4'b0100}, "R5");
    drive('0, {4'b0100, 4'b0010}, "R5");
    drive('0, {4'b1000, 4'b0001}, "R5");
    // R6 R7: spacer and multi-wire nibbles
    drive('0, {4'b0000, 4'b0000}, "R6");
    drive('0, {4'b0011, 4'b0100}, "R6");
    drive('0, {4'b1111, 4'b0000}, "R7");
    drive('0, {4'b1000, 4'b1001}, "R7");
    // R8 R9: one digit data, the other spacer
    drive({4'b0000, 4'b1010}, {4'b0000, 4'b0010}, "R8");
    drive({4'b0101, 4'b1010}, {4'b0100, 4'b0010}, "R9");
    drive('0, '0, "R9");
    drive('0, '0, "R10");
    repeat (3) @(posedge clk);
    #2;
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule